// File: doc/BRIEF.md
# Self-Timed Access Pulse Sequencer

This block drives the internal timing of one memory access. A start request, sampled on the fast timing clock, launches a fixed sequence of pulses: the word-line pulse, and then either the sense-amplifier enable (read) or the write-driver window (write). Every width and delay is a count of timing-clock ticks. The external access clock plays no part in it. A read margin code lengthens both the word-line pulse and the delay before sensing. A separate write margin code lengthens the write-driver window. A larger code therefore always gives a longer access.

Each sequence ends with a one-tick done pulse. A busy flag is high while the sequence runs. Start requests seen while busy are dropped. The direction and both margin codes count only in the tick in which a start is accepted.

The controller has seven named states. From IDLE, an accepted read goes to RD_WL and an accepted write goes to WR_LEAD. RD_WL holds the word line alone until the sense delay expires, then moves to RD_SENSE. RD_SENSE runs to the end of the word-line pulse and then moves to FIN. WR_LEAD lasts one tick, then moves to WR_DRIVE. WR_DRIVE holds the driver window for its length, then moves to WR_TAIL. WR_TAIL lasts one tick, then moves to FIN. FIN lasts one tick and returns to IDLE.

Top module: `stpg_top`

## Requirements
- R1: While reset is asserted and in the first tick after it is released, word line, sense enable, write enable, read-valid, done and busy are all low.
- R2: A read is requested with start high and is_write = 0. It is accepted at the clock edge where the controller is idle. The word line is high from the tick after that edge, for exactly BASE_WL + rd_margin ticks, where rd_margin is read as an unsigned value.
- R3: On a read, sense enable rises BASE_SAE + rd_margin ticks after the first word-line tick. It stays high until the word line falls, falls with it, and is never high while the word line is low.
- R4: Read-valid is a one-tick strobe in the first tick of sense enable, and it never appears on a write.
- R5: A write is requested with is_write = 1. The word line is high for BASE_WR + wr_margin + 2 ticks. The write enable is high for the BASE_WR + wr_margin ticks strictly inside that pulse, starting one tick after the word line rises. It is never high while the word line is low. Sense enable stays low during a write.
- R6: Done is high for exactly one tick, the tick right after the last word-line tick.
- R7: Busy is high from the first word-line tick through the done tick, and low in every other tick.
- R8: A start request seen in any busy tick, including the done tick, is ignored. Direction and margin codes that change after acceptance do not alter the running sequence. Neither starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access request, sampled each tick |
| is_write_i | input | 1 | 1 = write access, 0 = read access |
| rd_margin_i | input | MARGIN_W | Read margin code (unsigned) |
| wr_margin_i | input | MARGIN_W | Write margin code (unsigned) |
| wl_o | output | 1 | Word-line pulse |
| sae_o | output | 1 | Sense-amplifier enable |
| wde_o | output | 1 | Write-driver enable window |
| rd_valid_o | output | 1 | Read-data-valid strobe |
| done_o | output | 1 | Sequence-complete pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
A new start request can fall in the same tick as the done pulse. It can also fall in any other busy tick, and each time it carries a different direction and new margin codes. The bench provokes this by holding start high through the whole sequence and its done tick, with the other inputs randomised in every tick. It drops the request only once the controller is idle. The trace must match the lengths of the accepted access exactly, and the tick after done must show busy and word line low.

// File: rtl/stpg_pkg.sv
package stpg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WL,
        ST_RD_SENSE,
        ST_WR_LEAD,
        ST_WR_DRIVE,
        ST_WR_TAIL,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/stpg_margin.sv
module stpg_margin #(
    parameter int MARGIN_W = 3,
    parameter int BASE_SAE = 2,
    parameter int BASE_WR  = 3,
    parameter int CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic [MARGIN_W-1:0] rd_code_i,
    input  logic [MARGIN_W-1:0] wr_code_i,
    output logic [CNT_W-1:0]    sae_delay_o,
    output logic [CNT_W-1:0]    wr_len_o
);

    logic [MARGIN_W-1:0] wr_code_q;

    // The write code is captured at acceptance; its window starts a tick later.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_code_q <= '0;
        end else if (accept_i) begin
            wr_code_q <= wr_code_i;
        end
    end

    // The read delay is loaded in the accepting tick, so it uses the live code.
    assign sae_delay_o = CNT_W'(BASE_SAE) + CNT_W'(rd_code_i);
    assign wr_len_o    = CNT_W'(BASE_WR) + CNT_W'(wr_code_q);

endmodule

// File: rtl/stpg_tick_cnt.sv
module stpg_tick_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Loaded with a phase length N, it reports last in the N-th tick of the phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/stpg_fsm.sv
module stpg_fsm
    import stpg_pkg::*;
#(
    parameter int BASE_WL  = 6,
    parameter int BASE_SAE = 2,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_write_i,
    input  logic             last_i,
    input  logic [CNT_W-1:0] sae_delay_i,
    input  logic [CNT_W-1:0] wr_len_i,
    output logic             accept_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             wl_o,
    output logic             sae_o,
    output logic             wde_o,
    output logic             rd_valid_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam logic [CNT_W-1:0] SENSE_LEN = CNT_W'(BASE_WL - BASE_SAE);

    seq_state_t state_q, state_d;
    logic       rv_q;

    // Next state and counter loads
    always_comb begin
        state_d    = state_q;
        accept_o   = 1'b0;
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    if (is_write_i) begin
                        state_d = ST_WR_LEAD;
                    end else begin
                        state_d    = ST_RD_WL;
                        load_o     = 1'b1;
                        load_val_o = sae_delay_i;
                    end
                end
            end
            ST_RD_WL: begin
                if (last_i) begin
                    state_d    = ST_RD_SENSE;
                    load_o     = 1'b1;
                    load_val_o = SENSE_LEN;
                end
            end
            ST_RD_SENSE: begin
                if (last_i) state_d = ST_FIN;
            end
            ST_WR_LEAD: begin
                state_d    = ST_WR_DRIVE;
                load_o     = 1'b1;
                load_val_o = wr_len_i;
            end
            ST_WR_DRIVE: begin
                if (last_i) state_d = ST_WR_TAIL;
            end
            ST_WR_TAIL: state_d = ST_FIN;
            ST_FIN:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and registered read-valid strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rv_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rv_q    <= (state_q == ST_RD_WL) && last_i;
        end
    end

    // Pulse outputs decoded from the state
    always_comb begin
        wl_o   = 1'b0;
        sae_o  = 1'b0;
        wde_o  = 1'b0;
        done_o = 1'b0;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE:     busy_o = 1'b0;
            ST_RD_WL:    wl_o   = 1'b1;
            ST_RD_SENSE: begin wl_o = 1'b1; sae_o = 1'b1; end
            ST_WR_LEAD:  wl_o   = 1'b1;
            ST_WR_DRIVE: begin wl_o = 1'b1; wde_o = 1'b1; end
            ST_WR_TAIL:  wl_o   = 1'b1;
            ST_FIN:      done_o = 1'b1;
            default:     busy_o = 1'b0;
        endcase
    end

    assign rd_valid_o = rv_q;

endmodule

// File: rtl/stpg_top.sv
module stpg_top #(
    parameter int MARGIN_W = 3,
    parameter int BASE_WL  = 6,
    parameter int BASE_SAE = 2,
    parameter int BASE_WR  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                is_write_i,
    input  logic [MARGIN_W-1:0] rd_margin_i,
    input  logic [MARGIN_W-1:0] wr_margin_i,
    output logic                wl_o,
    output logic                sae_o,
    output logic                wde_o,
    output logic                rd_valid_o,
    output logic                done_o,
    output logic                busy_o
);

    localparam int MAX_LEN = ((BASE_WL > BASE_WR) ? BASE_WL : BASE_WR) + (1 << MARGIN_W);
    localparam int CNT_W   = $clog2(MAX_LEN) + 1;

    logic             accept;
    logic             load;
    logic             last;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] sae_delay;
    logic [CNT_W-1:0] wr_len;

    stpg_margin #(
        .MARGIN_W (MARGIN_W),
        .BASE_SAE (BASE_SAE),
        .BASE_WR  (BASE_WR),
        .CNT_W    (CNT_W)
    ) u_margin (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .rd_code_i   (rd_margin_i),
        .wr_code_i   (wr_margin_i),
        .sae_delay_o (sae_delay),
        .wr_len_o    (wr_len)
    );

    stpg_tick_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .last_o     (last)
    );

    stpg_fsm #(
        .BASE_WL  (BASE_WL),
        .BASE_SAE (BASE_SAE),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .is_write_i  (is_write_i),
        .last_i      (last),
        .sae_delay_i (sae_delay),
        .wr_len_i    (wr_len),
        .accept_o    (accept),
        .load_o      (load),
        .load_val_o  (load_val),
        .wl_o        (wl_o),
        .sae_o       (sae_o),
        .wde_o       (wde_o),
        .rd_valid_o  (rd_valid_o),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

endmodule

// File: rtl/stpg_chk.sv
module stpg_chk (
    input logic clk,
    input logic rst_n,
    input logic wl_o,
    input logic sae_o,
    input logic wde_o,
    input logic rd_valid_o,
    input logic done_o,
    input logic busy_o
);

    // R3
    sae_inside_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sae_o |-> wl_o);

    // R5
    wde_inside_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wde_o |-> wl_o);

    // R5
    no_sae_with_wde_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sae_o && wde_o));

    // R4
    rv_on_sae_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (sae_o && $rose(sae_o)));

    // R4
    sae_rise_gives_rv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sae_o) |-> rd_valid_o);

    // R6
    done_after_wl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wl_o) |-> done_o);

    // R6
    done_single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    busy_covers_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_o || done_o) |-> busy_o);

    // R8
    no_early_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R8
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !wl_o));

endmodule

bind stpg_top stpg_chk u_stpg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wl_o       (wl_o),
    .sae_o      (sae_o),
    .wde_o      (wde_o),
    .rd_valid_o (rd_valid_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
);

// File: tb/tb_stpg_top.sv
`timescale 1ns/1ps
module tb_stpg_top;

    localparam int MW  = 3;
    localparam int BWL = 6;
    localparam int BSA = 2;
    localparam int BWR = 3;
    localparam int CMAX = (1 << MW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          is_write_i = 1'b0;
    logic [MW-1:0] rd_margin_i = '0;
    logic [MW-1:0] wr_margin_i = '0;
    logic          wl_o, sae_o, wde_o, rd_valid_o, done_o, busy_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    stpg_top #(.MARGIN_W(MW), .BASE_WL(BWL), .BASE_SAE(BSA), .BASE_WR(BWR)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
        .rd_margin_i(rd_margin_i), .wr_margin_i(wr_margin_i),
        .wl_o(wl_o), .sae_o(sae_o), .wde_o(wde_o), .rd_valid_o(rd_valid_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    // Expected level of signal s in tick c (tick 0 = first tick after acceptance).
    // s: 0 wl, 1 sae, 2 wde, 3 rd_valid, 4 done, 5 busy
    function automatic logic exp_sig(int s, bit wr, int c, int rc, int wc);
        int w, d, sd;
        w  = BWL + rc;
        sd = BSA + rc;
        d  = BWR + wc;
        if (!wr) begin
            case (s)
                0: return c < w;
                1: return (c >= sd) && (c < w);
                3: return c == sd;
                4: return c == w;
                5: return c <= w;
                default: return 1'b0;
            endcase
        end else begin
            case (s)
                0: return c <= d + 1;
                2: return (c >= 1) && (c <= d);
                4: return c == d + 2;
                5: return c <= d + 2;
                default: return 1'b0;
            endcase
        end
    endfunction

    function automatic string sig_tag(int s, bit wr, bit disturb);
        string t;
        case (s)
            0: t = wr ? "R5 wl" : "R2 wl";
            1: t = "R3 sae";
            2: t = "R5 wde";
            3: t = "R4 rd_valid";
            4: t = "R6 done";
            default: t = "R7 busy";
        endcase
        if (disturb) t = {"R8 ", t};
        return t;
    endfunction

    task automatic run_access(bit wr, int rc, int wc, bit disturb);
        int   n;
        logic got [6];
        bit   bad [6];
        int   bad_c [6];
        logic bad_g [6];
        logic bad_e [6];
        for (int s = 0; s < 6; s++) bad[s] = 1'b0;
        n = wr ? (BWR + wc + 2) : (BWL + rc);
        is_write_i  = wr;
        rd_margin_i = MW'(rc);
        wr_margin_i = MW'(wc);
        start_i     = 1'b1;
        @(posedge clk);
        for (int c = 0; c <= n + 1; c++) begin
            @(negedge clk);
            got[0] = wl_o; got[1] = sae_o; got[2] = wde_o;
            got[3] = rd_valid_o; got[4] = done_o; got[5] = busy_o;
            for (int s = 0; s < 6; s++) begin
                logic e;
                e = exp_sig(s, wr, c, rc, wc);
                if (got[s] !== e && !bad[s]) begin
                    bad[s] = 1'b1; bad_c[s] = c; bad_g[s] = got[s]; bad_e[s] = e;
                end
            end
            if (disturb && c <= n) begin
                start_i     = 1'b1;
                is_write_i  = 1'($urandom);
                rd_margin_i = MW'($urandom);
                wr_margin_i = MW'($urandom);
            end else begin
                start_i = 1'b0;
            end
        end
        for (int s = 0; s < 6; s++) begin
            tests++;
            if (bad[s]) begin
                fails++;
                $display("FAIL %s: wr=%0d rc=%0d wc=%0d tick %0d actual=%b expected=%b",
                         sig_tag(s, wr, disturb), wr, rc, wc, bad_c[s], bad_g[s], bad_e[s]);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        tests++;
        if ({wl_o, sae_o, wde_o, rd_valid_o, done_o, busy_o} !== 6'b0) begin
            fails++;
            $display("FAIL R1 in reset: actual=%b expected=000000",
                     {wl_o, sae_o, wde_o, rd_valid_o, done_o, busy_o});
        end
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if ({wl_o, sae_o, wde_o, rd_valid_o, done_o, busy_o} !== 6'b0) begin
            fails++;
            $display("FAIL R1 after release: actual=%b expected=000000",
                     {wl_o, sae_o, wde_o, rd_valid_o, done_o, busy_o});
        end
        // Directed corners: minimum and maximum codes in both directions
        run_access(1'b0, 0, 0, 1'b0);
        run_access(1'b0, CMAX, 0, 1'b0);
        run_access(1'b1, 0, 0, 1'b0);
        run_access(1'b1, 0, CMAX, 1'b0);
        // Start held through busy and done with changing inputs
        run_access(1'b0, 1, 5, 1'b1);
        run_access(1'b1, 6, 2, 1'b1);
        run_access(1'b0, CMAX, CMAX, 1'b1);
        // Constrained random mix
        for (int i = 0; i < 60; i++) begin
            run_access(1'($urandom), int'($urandom_range(CMAX, 0)),
                       int'($urandom_range(CMAX, 0)), ($urandom_range(3, 0) == 0));
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R7 watchdog: sequence never completed, actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule